// File: doc/BRIEF.md
# Interrupt Status and Index Logic

This block collects interrupt events from a group of peripheral sources into a raw status register. It gates that register with a mask to form a masked status, and raises one combined interrupt line toward the processor. Software reaches the state through a small word-addressed register port. The port has raw status, mask, masked status and clear registers, plus an index register.

A read of the index register returns the number of the most urgent pending source. The same read clears that source's status bit in the same clock edge, so a handler can loop on the index until it reads zero. A handler can also read the masked status and write the bits it saw back to the clear register.

Event inputs are one-cycle pulses. The register port is plain: one access per cycle, with no back-pressure. A read returns its data on `rd_data` together with a one-cycle `rd_valid` pulse in the cycle after the access.

Top module: `irq_index_ctrl`

## Requirements
- R1: A pulse on `evt_i[n]` sets raw status bit n at the next rising clock edge. Raw status reads at word address 0, with source n in data bit n.
- R2: The mask register at address 1 is written and read back whole. The masked status at address 2 reads as the bitwise AND of raw status and mask.
- R3: `irq_o` is high exactly while at least one masked status bit is set.
- R4: Writing to address 3 clears every raw status bit whose data bit is 1. Data bits that are 0 leave their raw bits unchanged.
- R5: An event on a source wins over a clear of that source in the same cycle, whether the clear comes from an address-3 write or from an index read.
- R6: Writing the mask never changes raw status. A bit captured while masked shows in the masked status once its mask bit is set.
- R7: A read of address 4 returns n+1 for the lowest-numbered source n that is both raw-set and unmasked. Source 0 has the highest priority. The read returns 0 when no such source exists.
- R8: An index read that returns a nonzero value clears only that source's raw bit, at the edge of the read strobe. An index read returning 0 changes no state.
- R9: Active-low synchronous reset clears raw status and mask, drives `irq_o` low and `rd_valid` low.
- R10: Read data appears on `rd_data` with `rd_valid` high in the cycle after the read strobe. `rd_valid` is low after writes and idle cycles.
- R11: Reads of unmapped addresses (5 to 7) return 0. Writes to addresses 0, 2, 4 and to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | Single-cycle event pulses, one per source |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Word address of the register |
| acc_wdata | input | DW | Write data |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest cases to reach from the ports are the collisions. One is an event that lands in the very cycle its bit is being cleared, either by a clear-register write or by an index read that selects that same source. The bench drives the event pulse and the access strobe at the same falling edge, so both reach the design at one rising edge. It then reads raw status to confirm that the bit survived. A second hard case is a masked bit lying above a higher-priority unmasked bit. The bench drains the index register and checks that the masked bit is never returned and never lost.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;

  // Word addresses of the register port. The index register's read
  // side-effect depends on its decode.
  typedef enum logic [2:0] {
    RS_RAW  = 3'd0,
    RS_MASK = 3'd1,
    RS_ACT  = 3'd2,
    RS_CLR  = 3'd3,
    RS_IDX  = 3'd4
  } reg_sel_e;

  localparam int unsigned ADDR_W = 3;

  // Width needed to hold the values 0 .. nsrc.
  function automatic int unsigned idx_width(input int unsigned nsrc);
    return $clog2(nsrc + 1);
  endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  sel_o
);
  // Lowest set position wins. The code is position+1, and 0 means none.
  always_comb begin
    idx_o = '0;
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IW'(i + 1);
        sel_o = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] raw_q, mask_q;

  // Per-bit capture. A set has priority over a clear in the same cycle.
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          raw_q[g] <= 1'b0;
      else if (evt_i[g])   raw_q[g] <= 1'b1;
      else if (clr_i[g])   raw_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_idx_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  input  logic [N-1:0]      raw_i,
  input  logic [N-1:0]      mask_i,
  input  logic [IW-1:0]     top_idx_i,
  output logic [N-1:0]      clr_wr_o,
  output logic              mask_we_o,
  output logic [N-1:0]      mask_wdata_o,
  output logic              idx_rd_o,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  logic          wr_stb, rd_stb;
  logic [DW-1:0] rd_mux;

  assign wr_stb = acc_en && acc_we;
  assign rd_stb = acc_en && !acc_we;

  assign mask_we_o    = wr_stb && (acc_addr == RS_MASK);
  assign mask_wdata_o = acc_wdata[N-1:0];
  assign clr_wr_o     = (wr_stb && (acc_addr == RS_CLR)) ? acc_wdata[N-1:0] : '0;
  assign idx_rd_o     = rd_stb && (acc_addr == RS_IDX);

  always_comb begin
    unique case (acc_addr)
      RS_RAW:  rd_mux = DW'(raw_i);
      RS_MASK: rd_mux = DW'(mask_i);
      RS_ACT:  rd_mux = DW'(raw_i & mask_i);
      RS_IDX:  rd_mux = DW'(top_idx_i);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_index_ctrl.sv
module irq_index_ctrl
  import irq_idx_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              irq_o
);
  localparam int unsigned IW = idx_width(NSRC);

  logic [NSRC-1:0] raw_q, mask_q, act_w, sel_w, clr_wr_w, clr_all_w, mask_wdata_w;
  logic [IW-1:0]   top_idx_w;
  logic            mask_we_w, idx_rd_w;

  assign act_w = raw_q & mask_q;

  irq_prio_enc #(.N(NSRC), .IW(IW)) u_enc (
    .req_i (act_w),
    .idx_o (top_idx_w),
    .sel_o (sel_w)
  );

  irq_reg_port #(.N(NSRC), .DW(DW), .IW(IW)) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en       (acc_en),
    .acc_we       (acc_we),
    .acc_addr     (acc_addr),
    .acc_wdata    (acc_wdata),
    .raw_i        (raw_q),
    .mask_i       (mask_q),
    .top_idx_i    (top_idx_w),
    .clr_wr_o     (clr_wr_w),
    .mask_we_o    (mask_we_w),
    .mask_wdata_o (mask_wdata_w),
    .idx_rd_o     (idx_rd_w),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid)
  );

  // Clear sources: software clear write, or the bit chosen by an index read.
  assign clr_all_w = clr_wr_w | (idx_rd_w ? sel_w : '0);

  irq_status_bank #(.N(NSRC)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_i),
    .clr_i        (clr_all_w),
    .mask_we_i    (mask_we_w),
    .mask_wdata_i (mask_wdata_w),
    .raw_o        (raw_q),
    .mask_o       (mask_q)
  );

  assign irq_o = |act_w;
endmodule

// File: rtl/irq_index_chk.sv
module irq_index_chk #(
  parameter int unsigned NSRC = 32,
  parameter int unsigned DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] evt_i,
  input logic            acc_en,
  input logic            acc_we,
  input logic [2:0]      acc_addr,
  input logic [DW-1:0]   acc_wdata,
  input logic            rd_valid,
  input logic            irq_o,
  input logic [NSRC-1:0] raw_q,
  input logic [NSRC-1:0] mask_q
);
  // R1
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R4
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr == 3'd3)
      |=> ((raw_q & $past(acc_wdata[NSRC-1:0]) & ~$past(evt_i)) == '0));

  // R6
  mask_keeps_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr == 3'd1)
      |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  // R10
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we) |=> rd_valid);

  // R10
  rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> !rd_valid);

  // R3
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((raw_q & mask_q) != '0));
endmodule

bind irq_index_ctrl irq_index_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .acc_en    (acc_en),
  .acc_we    (acc_we),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .rd_valid  (rd_valid),
  .irq_o     (irq_o),
  .raw_q     (raw_q),
  .mask_q    (mask_q)
);

// File: tb/sim_irq_index_ctrl.sv
module sim_irq_index_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  irq_index_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_o(irq_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_addr = a;
    @(negedge clk);
    acc_en = 0;
    d = rd_data;
    chk(rd_valid === 1'b1, "R10", 32'(rd_valid), 32'd1);
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); evt_i = v;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic clean();
    wr(3'd1, 32'h0);
    wr(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq_o === 1'b0, "R9", 32'(irq_o), 0);
    chk(rd_valid === 1'b0, "R9", 32'(rd_valid), 0);
    rd(3'd0, d); chk(d === 0, "R9", d, 0);
    rd(3'd1, d); chk(d === 0, "R9", d, 0);
    rd(3'd4, d); chk(d === 0, "R7", d, 0);
    @(negedge clk);
    chk(rd_valid === 1'b0, "R10", 32'(rd_valid), 0);
  endtask

  task automatic t_capture_mask();
    logic [31:0] d;
    clean();
    pulse(32'h8000_0005);
    rd(3'd0, d); chk(d === 32'h8000_0005, "R1", d, 32'h8000_0005);
    rd(3'd2, d); chk(d === 0, "R2", d, 0);
    chk(irq_o === 1'b0, "R3", 32'(irq_o), 0);
    wr(3'd1, 32'h0000_0005);
    rd(3'd1, d); chk(d === 32'h5, "R2", d, 32'h5);
    rd(3'd2, d); chk(d === 32'h5, "R2", d, 32'h5);
    chk(irq_o === 1'b1, "R3", 32'(irq_o), 1);
  endtask

  task automatic t_index_drain();
    logic [31:0] d;
    // state: raw 8000_0005, mask 5
    rd(3'd4, d); chk(d === 32'd1, "R7", d, 1);
    rd(3'd0, d); chk(d === 32'h8000_0004, "R8", d, 32'h8000_0004);
    rd(3'd4, d); chk(d === 32'd3, "R7", d, 3);
    rd(3'd0, d); chk(d === 32'h8000_0000, "R8", d, 32'h8000_0000);
    chk(irq_o === 1'b0, "R3", 32'(irq_o), 0);
    rd(3'd4, d); chk(d === 0, "R7", d, 0);
    rd(3'd0, d); chk(d === 32'h8000_0000, "R8", d, 32'h8000_0000);
  endtask

  task automatic t_unmask();
    logic [31:0] d;
    // raw bit 31 still set while masked
    wr(3'd1, 32'h0);
    rd(3'd0, d); chk(d === 32'h8000_0000, "R6", d, 32'h8000_0000);
    wr(3'd1, 32'h8000_0000);
    rd(3'd2, d); chk(d === 32'h8000_0000, "R6", d, 32'h8000_0000);
    rd(3'd4, d); chk(d === 32'd32, "R7", d, 32);
    rd(3'd0, d); chk(d === 0, "R8", d, 0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    clean();
    pulse(32'h0000_F0F0);
    wr(3'd3, 32'h0);
    rd(3'd0, d); chk(d === 32'h0000_F0F0, "R4", d, 32'h0000_F0F0);
    wr(3'd3, 32'h0000_3030);
    rd(3'd0, d); chk(d === 32'h0000_C0C0, "R4", d, 32'h0000_C0C0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    clean();
    pulse(32'h0000_0004);
    // clear write of bit 2 collides with a new event on bit 2
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = 3'd3; acc_wdata = 32'h4; evt_i = 32'h4;
    @(negedge clk);
    acc_en = 0; acc_we = 0; evt_i = '0;
    rd(3'd0, d); chk(d === 32'h4, "R5", d, 32'h4);
    // index read selecting bit 2 collides with a new event on bit 2
    wr(3'd1, 32'h4);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_addr = 3'd4; evt_i = 32'h4;
    @(negedge clk);
    acc_en = 0; evt_i = '0;
    d = rd_data;
    chk(d === 32'd3, "R7", d, 3);
    rd(3'd0, d); chk(d === 32'h4, "R5", d, 32'h4);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    clean();
    pulse(32'h0000_0100);
    wr(3'd1, 32'h0000_0100);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd0, d); chk(d === 32'h100, "R11", d, 32'h100);
    rd(3'd1, d); chk(d === 32'h100, "R11", d, 32'h100);
    rd(3'd5, d); chk(d === 0, "R11", d, 0);
    rd(3'd7, d); chk(d === 0, "R11", d, 0);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk(irq_o === 1'b0, "R9", 32'(irq_o), 0);
    rd(3'd0, d); chk(d === 0, "R9", d, 0);
    rd(3'd1, d); chk(d === 0, "R9", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_capture_mask();
    t_index_drain();
    t_unmask();
    t_clear();
    t_race();
    t_unmapped();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule